// File: doc/BRIEF.md
# Converter Calibration Sequencer

This block runs offset and gain calibration for a data converter. Software picks a calibration by writing a 3-bit mode field in the control register. The sequencer then selects the converter input source and requests one conversion per step. It captures the signed 24-bit result and turns it into a coefficient.

An offset step keeps the raw sample as the new offset. A gain step divides an ideal full-scale code, scaled to fixed point, by the measured sample minus the offset. It uses a bit-serial divider and clamps the result to 24 bits. New coefficients go into their software-visible registers only when the whole command finishes. At that point the mode field drops back to idle, a sticky done flag and an interrupt flag are set, and the block is ready for the next command.

The converter is reached through a request/valid handshake. The gain coefficient is unsigned fixed point with `GAIN_FRAC` fraction bits, so the reset value `1 << GAIN_FRAC` means unity gain.

Top module: `adc_cal_seq`

## Requirements
- R1: After reset, mode_o is 0, busy_o, done_o, irq_o and conv_req_o are 0, offset_o is 0 and gain_o is 24'h400000 (unity).
- R2: A write to address 0 with wr_data_i[2:0] in 1..5 while not busy starts a calibration. busy_o is 1 and mode_o holds the written value from the cycle after the write until completion. The encodings are 1 internal offset, 2 internal gain, 3 full internal, 4 system offset and 5 system gain.
- R3: On completion, mode_o returns to 0, busy_o goes to 0, and done_o and irq_o go to 1, all in the same cycle.
- R4: done_o and irq_o are cleared only by a write to address 0 with wr_data_i[8] set. Writes to the coefficient registers and control writes with bit 8 clear leave them set.
- R5: While conv_req_o is high, in_sel_o is 2'b01 (ground) for an internal offset step, 2'b10 (internal full scale) for an internal gain step and 2'b00 (external pins) for both system modes. It is never 2'b11.
- R6: Mode 3 runs a ground offset step and then a full-scale gain step in one command. The gain step uses the offset just measured, and there is a single completion.
- R7: An offset step sets the offset coefficient to the raw two's-complement sample.
- R8: A gain step sets the gain coefficient to floor(24'h7FFFFF * 2^22 / (sample - offset)), with the difference taken as a signed 25-bit value. The result is 24'hFFFFFF if the difference is zero or negative, or if the quotient exceeds 24'hFFFFFF.
- R9: offset_o and gain_o do not change while a calibration is in progress, unless software writes them.
- R10: A write to address 1 loads offset_o and a write to address 2 loads gain_o from wr_data_i.
- R11: A mode write while busy is ignored. The running command and mode_o are unaffected and no extra calibration follows.
- R12: Mode encodings 0, 6 and 7 act as idle: no conversion is requested and busy_o stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 control, 1 offset, 2 gain |
| wr_data_i | input | CW | Write data |
| mode_o | output | 3 | Current mode field |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | Sticky calibration-done flag |
| irq_o | output | 1 | Interrupt flag |
| offset_o | output | CW | Offset coefficient |
| gain_o | output | CW | Gain coefficient |
| conv_req_o | output | 1 | Conversion request |
| in_sel_o | output | 2 | Converter input source select |
| conv_valid_i | input | 1 | Conversion result valid |
| conv_data_i | input | CW | Signed conversion result |

## Verification
The hardest case to reach is a second mode write that lands during a running gain step. If the block wrongly accepted it, a new calibration would start only after completion, and nothing would show at the moment of the write. The bench starts a system gain calibration, writes an offset mode while the converter model is still holding back its response, and then waits many cycles after completion. In that time it confirms that no conversion is requested again and that the offset coefficient keeps its old value. The saturating gain cases are set up by loading an offset larger than the later gain sample, and by using a sample only just above the offset.

// File: rtl/adc_cal_pkg.sv
`timescale 1ns/1ps
package adc_cal_pkg;
  localparam logic [2:0] MODE_IDLE     = 3'd0;
  localparam logic [2:0] MODE_INT_OFF  = 3'd1;
  localparam logic [2:0] MODE_INT_GAIN = 3'd2;
  localparam logic [2:0] MODE_INT_FULL = 3'd3;
  localparam logic [2:0] MODE_SYS_OFF  = 3'd4;
  localparam logic [2:0] MODE_SYS_GAIN = 3'd5;

  localparam logic [1:0] SEL_EXT  = 2'b00;
  localparam logic [1:0] SEL_GND  = 2'b01;
  localparam logic [1:0] SEL_FULL = 2'b10;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_OFF  = 2'd1;
  localparam logic [1:0] ADDR_GAIN = 2'd2;

  localparam int CLR_BIT = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_CONV, ST_DIV, ST_FIN} cal_state_e;

  function automatic logic mode_is_cal(logic [2:0] m);
    return (m >= MODE_INT_OFF) && (m <= MODE_SYS_GAIN);
  endfunction
endpackage

// File: rtl/adc_cal_div.sv
`timescale 1ns/1ps
module adc_cal_div #(
  parameter int N_W = 46,
  parameter int D_W = 24
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           start_i,
  input  logic [N_W-1:0] num_i,
  input  logic [D_W-1:0] den_i,
  output logic           done_o,
  output logic [N_W-1:0] quot_o
);
  localparam int CNT_W = $clog2(N_W + 1);
  localparam logic [CNT_W-1:0] CNT_INIT = CNT_W'(N_W);

  logic             run_q, done_q;
  logic [CNT_W-1:0] cnt_q;
  logic [D_W-1:0]   rem_q, den_q;
  logic [N_W-1:0]   quot_q;
  logic [D_W:0]     rem_sh, rem_sub;
  logic             ge;

  // restoring step: shift in next numerator bit, subtract if it fits
  always_comb begin
    rem_sh  = {rem_q, quot_q[N_W-1]};
    ge      = rem_sh >= {1'b0, den_q};
    rem_sub = rem_sh - {1'b0, den_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      den_q  <= '0;
      quot_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i) begin
        run_q  <= 1'b1;
        cnt_q  <= CNT_INIT;
        rem_q  <= '0;
        den_q  <= den_i;
        quot_q <= num_i;
      end else if (run_q) begin
        rem_q  <= ge ? rem_sub[D_W-1:0] : rem_sh[D_W-1:0];
        quot_q <= {quot_q[N_W-2:0], ge};
        cnt_q  <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q  <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_q;
  assign quot_o = quot_q;
endmodule

// File: rtl/adc_cal_regs.sv
`timescale 1ns/1ps
module adc_cal_regs
  import adc_cal_pkg::*;
#(
  parameter int             CW       = 24,
  parameter logic [CW-1:0]  GAIN_RST = CW'(1) << 22
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  input  logic          cal_done_i,
  input  logic          off_commit_i,
  input  logic [CW-1:0] off_new_i,
  input  logic          gain_commit_i,
  input  logic [CW-1:0] gain_new_i,
  output logic [2:0]    mode_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o,
  output logic [CW-1:0] offset_o,
  output logic [CW-1:0] gain_o
);
  logic [2:0]    mode_q;
  logic          done_q, irq_q;
  logic [CW-1:0] off_q, gain_q;
  logic          ctrl_wr, clr_wr;

  assign ctrl_wr = wr_en_i && (wr_addr_i == ADDR_CTRL);
  assign clr_wr  = ctrl_wr && wr_data_i[CLR_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_IDLE;
      done_q <= 1'b0;
      irq_q  <= 1'b0;
      off_q  <= '0;
      gain_q <= GAIN_RST;
    end else begin
      // mode field self-clears; new command accepted only while idle
      if (cal_done_i)
        mode_q <= MODE_IDLE;
      else if (ctrl_wr && (mode_q == MODE_IDLE) && mode_is_cal(wr_data_i[2:0]))
        mode_q <= wr_data_i[2:0];

      if (cal_done_i) begin
        done_q <= 1'b1;
        irq_q  <= 1'b1;
      end else if (clr_wr) begin
        done_q <= 1'b0;
        irq_q  <= 1'b0;
      end

      if (off_commit_i)
        off_q <= off_new_i;
      else if (wr_en_i && (wr_addr_i == ADDR_OFF))
        off_q <= wr_data_i;

      if (gain_commit_i)
        gain_q <= gain_new_i;
      else if (wr_en_i && (wr_addr_i == ADDR_GAIN))
        gain_q <= wr_data_i;
    end
  end

  assign mode_o   = mode_q;
  assign busy_o   = (mode_q != MODE_IDLE);
  assign done_o   = done_q;
  assign irq_o    = irq_q;
  assign offset_o = off_q;
  assign gain_o   = gain_q;
endmodule

// File: rtl/adc_cal_ctrl.sv
`timescale 1ns/1ps
module adc_cal_ctrl
  import adc_cal_pkg::*;
#(
  parameter int            CW         = 24,
  parameter int            N_W        = 46,
  parameter logic [CW-1:0] FULL_SCALE = 24'h7FFFFF,
  parameter int            GAIN_FRAC  = 22
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [2:0]     mode_i,
  input  logic [CW-1:0]  offset_i,
  input  logic           conv_valid_i,
  input  logic [CW-1:0]  conv_data_i,
  output logic           conv_req_o,
  output logic [1:0]     in_sel_o,
  output logic           div_start_o,
  output logic [N_W-1:0] div_num_o,
  output logic [CW-1:0]  div_den_o,
  input  logic           div_done_i,
  input  logic [N_W-1:0] div_quot_i,
  output logic           cal_done_o,
  output logic           off_commit_o,
  output logic [CW-1:0]  off_new_o,
  output logic           gain_commit_o,
  output logic [CW-1:0]  gain_new_o
);
  localparam logic [N_W-1:0] DIV_NUM = N_W'(FULL_SCALE) << GAIN_FRAC;

  cal_state_e     state_q;
  logic           gain_step_q, off_upd_q, gain_upd_q;
  logic [CW-1:0]  off_work_q, gain_res_q;
  logic signed [CW:0] diff;
  logic           diff_pos, accept, sys_mode, quot_ovf;

  assign accept   = (state_q == ST_CONV) && conv_valid_i;
  assign diff     = $signed({conv_data_i[CW-1], conv_data_i})
                  - $signed({off_work_q[CW-1], off_work_q});
  assign diff_pos = !diff[CW] && (diff != '0);
  assign sys_mode = (mode_i == MODE_SYS_OFF) || (mode_i == MODE_SYS_GAIN);
  assign quot_ovf = |div_quot_i[N_W-1:CW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      gain_step_q <= 1'b0;
      off_upd_q   <= 1'b0;
      gain_upd_q  <= 1'b0;
      off_work_q  <= '0;
      gain_res_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (mode_is_cal(mode_i)) begin
          state_q     <= ST_CONV;
          gain_step_q <= (mode_i == MODE_INT_GAIN) || (mode_i == MODE_SYS_GAIN);
          off_work_q  <= offset_i;
          off_upd_q   <= 1'b0;
          gain_upd_q  <= 1'b0;
        end
        ST_CONV: if (conv_valid_i) begin
          if (!gain_step_q) begin
            off_work_q <= conv_data_i;
            off_upd_q  <= 1'b1;
            if (mode_i == MODE_INT_FULL) gain_step_q <= 1'b1;
            else                         state_q     <= ST_FIN;
          end else begin
            gain_upd_q <= 1'b1;
            if (diff_pos) begin
              state_q <= ST_DIV;
            end else begin
              gain_res_q <= '1;
              state_q    <= ST_FIN;
            end
          end
        end
        ST_DIV: if (div_done_i) begin
          gain_res_q <= quot_ovf ? '1 : div_quot_i[CW-1:0];
          state_q    <= ST_FIN;
        end
        ST_FIN: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign conv_req_o    = (state_q == ST_CONV);
  assign in_sel_o      = sys_mode ? SEL_EXT : (gain_step_q ? SEL_FULL : SEL_GND);
  assign div_start_o   = accept && gain_step_q && diff_pos;
  assign div_num_o     = DIV_NUM;
  assign div_den_o     = diff[CW-1:0];
  assign cal_done_o    = (state_q == ST_FIN);
  assign off_commit_o  = (state_q == ST_FIN) && off_upd_q;
  assign gain_commit_o = (state_q == ST_FIN) && gain_upd_q;
  assign off_new_o     = off_work_q;
  assign gain_new_o    = gain_res_q;
endmodule

// File: rtl/adc_cal_seq.sv
`timescale 1ns/1ps
module adc_cal_seq #(
  parameter int            CW         = 24,
  parameter int            GAIN_FRAC  = 22,
  parameter logic [CW-1:0] FULL_SCALE = 24'h7FFFFF
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [CW-1:0] wr_data_i,
  output logic [2:0]    mode_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          irq_o,
  output logic [CW-1:0] offset_o,
  output logic [CW-1:0] gain_o,
  output logic          conv_req_o,
  output logic [1:0]    in_sel_o,
  input  logic          conv_valid_i,
  input  logic [CW-1:0] conv_data_i
);
  localparam int            N_W      = CW + GAIN_FRAC;
  localparam logic [CW-1:0] GAIN_ONE = CW'(1) << GAIN_FRAC;

  logic           cal_done, off_commit, gain_commit;
  logic [CW-1:0]  off_new, gain_new, div_den;
  logic           div_start, div_done;
  logic [N_W-1:0] div_num, div_quot;

  adc_cal_regs #(.CW(CW), .GAIN_RST(GAIN_ONE)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .cal_done_i   (cal_done),
    .off_commit_i (off_commit),
    .off_new_i    (off_new),
    .gain_commit_i(gain_commit),
    .gain_new_i   (gain_new),
    .mode_o, .busy_o, .done_o, .irq_o, .offset_o, .gain_o
  );

  adc_cal_ctrl #(
    .CW(CW), .N_W(N_W), .FULL_SCALE(FULL_SCALE), .GAIN_FRAC(GAIN_FRAC)
  ) u_ctrl (
    .clk_i, .rst_ni,
    .mode_i        (mode_o),
    .offset_i      (offset_o),
    .conv_valid_i, .conv_data_i, .conv_req_o, .in_sel_o,
    .div_start_o   (div_start),
    .div_num_o     (div_num),
    .div_den_o     (div_den),
    .div_done_i    (div_done),
    .div_quot_i    (div_quot),
    .cal_done_o    (cal_done),
    .off_commit_o  (off_commit),
    .off_new_o     (off_new),
    .gain_commit_o (gain_commit),
    .gain_new_o    (gain_new)
  );

  adc_cal_div #(.N_W(N_W), .D_W(CW)) u_div (
    .clk_i, .rst_ni,
    .start_i(div_start),
    .num_i  (div_num),
    .den_i  (div_den),
    .done_o (div_done),
    .quot_o (div_quot)
  );
endmodule

// File: rtl/adc_cal_seq_chk.sv
`timescale 1ns/1ps
module adc_cal_seq_chk #(
  parameter int CW = 24
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          wr_en_i,
  input logic [1:0]    wr_addr_i,
  input logic [CW-1:0] wr_data_i,
  input logic [2:0]    mode_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          irq_o,
  input logic [CW-1:0] offset_o,
  input logic [CW-1:0] gain_o,
  input logic          conv_req_o,
  input logic [1:0]    in_sel_o
);
  logic clr_wr, sw_coef_wr;
  assign clr_wr     = wr_en_i && (wr_addr_i == 2'd0) && wr_data_i[8];
  assign sw_coef_wr = wr_en_i && (wr_addr_i != 2'd0);

  // R3
  cal_complete_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> (done_o && irq_o && mode_o == 3'd0));

  // R4
  done_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clr_wr) |=> done_o);

  // R5
  in_sel_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_req_o |-> (in_sel_o != 2'b11));

  // R9
  coef_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !sw_coef_wr) |=> (!busy_o || ($stable(offset_o) && $stable(gain_o))));

  // R11
  mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> (!busy_o || $stable(mode_o)));

  // R12
  idle_no_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !conv_req_o);
endmodule

bind adc_cal_seq adc_cal_seq_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .mode_o(mode_o), .busy_o(busy_o), .done_o(done_o),
  .irq_o(irq_o), .offset_o(offset_o), .gain_o(gain_o),
  .conv_req_o(conv_req_o), .in_sel_o(in_sel_o)
);

// File: tb/adc_cal_seq_test.sv
`timescale 1ns/1ps
module adc_cal_seq_test;
  localparam int LAT = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_addr_i = 2'd0;
  logic [23:0] wr_data_i = 24'd0;
  logic [2:0]  mode_o;
  logic        busy_o, done_o, irq_o, conv_req_o;
  logic [23:0] offset_o, gain_o;
  logic [1:0]  in_sel_o;
  logic        conv_valid_i = 1'b0;
  logic [23:0] conv_data_i = 24'd0;

  adc_cal_seq uut (.*);

  always #2.5 clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  logic [23:0] gnd_s = 0, fs_s = 0, ext_s = 0;
  int nsel = 0;
  logic [1:0] sel_hist [2];

  // mode, ground sample, full-scale sample, external sample
  localparam logic [74:0] VEC [8] = '{
    {3'd1, 24'h000010, 24'h3FFFFF, 24'h000000},
    {3'd2, 24'h000000, 24'h400010, 24'h000000},
    {3'd3, 24'hFFFF9C, 24'h3F0000, 24'h000000},
    {3'd4, 24'h000000, 24'h000000, 24'hFFFFF0},
    {3'd5, 24'h000000, 24'h000000, 24'h200000},
    {3'd5, 24'h000000, 24'h000000, 24'hFFFFE0},
    {3'd5, 24'h000000, 24'h000000, 24'h000100},
    {3'd3, 24'h000005, 24'h7FFFFF, 24'h000000}
  };

  // converter model: answers LAT cycles after a request, data picked by in_sel
  initial begin
    int cnt;
    cnt = 0;
    forever begin
      @(negedge clk_i);
      if (conv_valid_i) begin
        conv_valid_i = 1'b0;
        cnt = 0;
      end else if (conv_req_o) begin
        cnt++;
        if (cnt >= LAT) begin
          conv_valid_i = 1'b1;
          conv_data_i = (in_sel_o == 2'b01) ? gnd_s : (in_sel_o == 2'b10) ? fs_s : ext_s;
          if (nsel < 2) sel_hist[nsel] = in_sel_o;
          nsel++;
        end
      end
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [23:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_idle(output logic stable);
    logic [23:0] o0, g0;
    int guard;
    o0 = offset_o; g0 = gain_o; stable = 1'b1; guard = 0;
    while (busy_o && guard < 2000) begin
      if (offset_o != o0 || gain_o != g0) stable = 1'b0;
      @(negedge clk_i);
      guard++;
    end
  endtask

  function automatic logic [23:0] exp_gain(logic [23:0] s, logic [23:0] o);
    longint d, q;
    d = longint'($signed(s)) - longint'($signed(o));
    if (d <= 0) return 24'hFFFFFF;
    q = (longint'(24'h7FFFFF) <<< 22) / d;
    if (q > 64'hFFFFFF) return 24'hFFFFFF;
    return q[23:0];
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [23:0] off_m, gain_m;
    logic stable;
    int n0;

    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(mode_o == 3'd0 && !busy_o && !done_o && !irq_o && !conv_req_o, "R1 flags",
        {mode_o, busy_o, done_o, irq_o, conv_req_o}, 0);
    chk(offset_o == 24'h0, "R1 offset", offset_o, 0);
    chk(gain_o == 24'h400000, "R1 gain", gain_o, 32'h400000);
    rst_ni = 1'b1;
    @(negedge clk_i);
    off_m = 24'h0; gain_m = 24'h400000;

    foreach (VEC[i]) begin
      logic [2:0] m;
      m = VEC[i][74:72];
      gnd_s = VEC[i][71:48]; fs_s = VEC[i][47:24]; ext_s = VEC[i][23:0];
      nsel = 0;
      wr(2'd0, {21'd0, m});
      chk(busy_o && mode_o == m, "R2 start", {mode_o, busy_o}, {m, 1'b1});
      wait_idle(stable);
      chk(stable, "R9 coefficients held while busy", stable, 1);
      chk(!busy_o && mode_o == 3'd0 && done_o && irq_o, "R3 completion",
          {mode_o, busy_o, done_o, irq_o}, 32'b0000011);
      case (m)
        3'd1: begin off_m = gnd_s;
          chk(sel_hist[0] == 2'b01 && nsel == 1, "R5 ground select", sel_hist[0], 1); end
        3'd2: begin gain_m = exp_gain(fs_s, off_m);
          chk(sel_hist[0] == 2'b10 && nsel == 1, "R5 full-scale select", sel_hist[0], 2); end
        3'd3: begin off_m = gnd_s; gain_m = exp_gain(fs_s, gnd_s);
          chk(nsel == 2 && sel_hist[0] == 2'b01 && sel_hist[1] == 2'b10, "R6 full sequence",
              {sel_hist[0], sel_hist[1], nsel[3:0]}, {2'b01, 2'b10, 4'd2}); end
        3'd4: begin off_m = ext_s;
          chk(sel_hist[0] == 2'b00 && nsel == 1, "R5 external select", sel_hist[0], 0); end
        default: begin gain_m = exp_gain(ext_s, off_m);
          chk(sel_hist[0] == 2'b00 && nsel == 1, "R5 external select", sel_hist[0], 0); end
      endcase
      chk(offset_o == off_m, "R7 offset coefficient", offset_o, off_m);
      chk(gain_o == gain_m, "R8 gain coefficient", gain_o, gain_m);
      wr(2'd0, 24'h000100);
      chk(!done_o && !irq_o, "R4 clear", {done_o, irq_o}, 0);
    end

    // R10 software coefficient load
    wr(2'd1, 24'h123456);
    wr(2'd2, 24'h0ABCDE);
    chk(offset_o == 24'h123456, "R10 offset write", offset_o, 32'h123456);
    chk(gain_o == 24'h0ABCDE, "R10 gain write", gain_o, 32'h0ABCDE);

    // R11 mode write during system gain calibration is ignored
    ext_s = 24'h300000; nsel = 0; gnd_s = 24'h000777;
    wr(2'd0, 24'd5);
    wr(2'd0, 24'd1);
    chk(mode_o == 3'd5, "R11 mode held", mode_o, 5);
    wait_idle(stable);
    repeat (30) @(negedge clk_i);
    chk(nsel == 1 && !busy_o, "R11 no extra calibration", nsel, 1);
    chk(offset_o == 24'h123456, "R11 offset untouched", offset_o, 32'h123456);
    chk(gain_o == exp_gain(24'h300000, 24'h123456), "R8 gain with loaded offset",
        gain_o, exp_gain(24'h300000, 24'h123456));

    // R4 done survives other writes
    wr(2'd1, 24'h000001);
    wr(2'd0, 24'h000000);
    chk(done_o && irq_o, "R4 done sticky", {done_o, irq_o}, 3);
    wr(2'd0, 24'h000100);
    chk(!done_o && !irq_o, "R4 clear by flag write", {done_o, irq_o}, 0);

    // R12 unused encodings
    n0 = nsel;
    wr(2'd0, 24'd6);
    chk(!busy_o && mode_o == 3'd0, "R12 mode 6 idle", {mode_o, busy_o}, 0);
    wr(2'd0, 24'd7);
    repeat (20) @(negedge clk_i);
    chk(!busy_o && mode_o == 3'd0 && nsel == n0 && !done_o, "R12 mode 7 idle",
        {mode_o, busy_o, done_o}, 0);

    // R8 zero difference saturates
    wr(2'd1, 24'h000100);
    ext_s = 24'h000100; nsel = 0;
    wr(2'd0, 24'd5);
    wait_idle(stable);
    chk(gain_o == 24'hFFFFFF, "R8 zero difference", gain_o, 32'hFFFFFF);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule